// File: doc/BRIEF.md
# Multi-State Trigger Sequencer

This block decides when a logic analyzer triggers and which samples it keeps. On each clock it receives a vector of trigger-term match bits and a strobe that marks a valid sample. The terms come from comparators, range checks and edge detectors that sit outside the block. The sequencer walks through up to sixteen programmable states. In each state three conditions are formed from the terms: hit, else and capture. Two internal timers are started and stopped by the sequencer's own actions, and their expiry flags are fed back as two extra trigger terms.

Each state's conditions and actions are loaded through a two-command configuration port. A select command sets a configuration address. Each following data command stores one word at that address and then steps the address forward, so a whole state can be written in one burst. Once configured, the sequencer is armed with a single pulse. From then on it reacts only to valid samples. The run flag stays set until reset, and the capture-enable output marks the samples that should be stored.

Top module: `trig_sequencer`

## Requirements
- R1: After reset the state is 0, run_o is low, capture_o is low, both timers are stopped, and every stored condition reads as "never true", so an armed sequencer with all terms high neither moves nor sets run_o.
- R2: A select cycle (cfg_sel_i) loads the address from cfg_data_i[7:0]. Each write cycle (cfg_wr_i without cfg_sel_i) stores cfg_data_i at that address and then adds one to it. When bit 7 of the address is 0, bits [6:3] pick the state and bits [2:0] pick the field: 0 = hit, 1 = else, 2 = capture, 3 = hit count, 4 = actions. Address 0x80+i holds the 36-bit limit of timer i.
- R3: A condition word holds a term mask in bits [9:0] (terms_i in bits 7:0, timer 0 in bit 8, timer 1 in bit 9) and a function in bits [14:12]: 0 AND, 1 NAND, 2 OR, 3 NOR, 4 XOR, 5 XNOR, 6 and 7 never true. The function is applied to the masked terms.
- R4: The sequencer changes nothing before it has been armed with arm_i, and it changes nothing on cycles where sample_valid_i is low.
- R5: A hit-count field N (bits [19:0]) makes the actions fire on the Nth valid cycle with the hit condition true in that state, with N = 0 treated as 1. The occurrence counter clears whenever the state is entered, including an else jump back to the same state.
- R6: The action word has these bits: bit 0 sets run_o, bits [2:1] start timers 0 and 1, bits [4:3] stop timers 0 and 1, bit 5 advances to the next state. run_o stays high until reset. An advance from state 15 stays at 15.
- R7: When the hit condition is false and the else condition is true, the state becomes the else target (action bits [11:8]). When both are true, the hit is served and the else condition is ignored.
- R8: On a valid cycle where neither hit nor else is true, the state stays the same.
- R9: capture_o is armed AND sample_valid_i AND (run_o OR the current state's capture condition), all in the same cycle.
- R10: A timer start clears the count and runs it, counting one per clock. A stop halts it and holds the count. When both come in the same cycle, stop wins. A timer's term bit is high while its count is at or above its limit. After reset the limit is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one timer tick per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_i | input | 1 | Pulse that starts the sequencer |
| sample_valid_i | input | 1 | Marks a cycle carrying a valid sample |
| terms_i | input | 8 | External trigger-term match bits |
| cfg_sel_i | input | 1 | Select command: load the configuration address |
| cfg_wr_i | input | 1 | Data command: store a word, then step the address |
| cfg_data_i | input | 36 | Address (bits 7:0) or data word |
| run_o | output | 1 | Sticky trigger/run flag |
| capture_o | output | 1 | Store the current sample |
| state_o | output | 4 | Current sequencer state |
| timer_run_o | output | 2 | Running flag of each timer |

## Verification
The assertions assume that the select and data commands never arrive in the same cycle and that arm_i comes only after configuration is done. The bench holds cfg_sel_i and cfg_wr_i apart and finishes every burst before it pulses arm_i. The bench also drives every input at the falling edge, so the checks on the combinational capture path see settled terms. Each scenario starts from a fresh reset, so no assertion depends on a configuration left over from the one before.

// File: rtl/tseq_pkg.sv
// Package: shared sizes, condition functions and configuration records
// for the trigger sequencer. All derived widths come from the few
// parameters at the top.
package tseq_pkg;
    parameter int STATES    = 16;
    parameter int EXT_TERMS = 8;
    parameter int TIMERS    = 2;
    parameter int TIMER_W   = 36;
    parameter int CNT_W     = 20;
    parameter int CFG_W     = 36;
    parameter int ADDR_W    = 8;

    localparam int TERMS = EXT_TERMS + TIMERS;
    localparam int ST_W  = $clog2(STATES);
    localparam int FLD_W = 3;

    // Field indices inside one state's slot of the address space.
    localparam logic [FLD_W-1:0] FLD_HIT  = 3'd0;
    localparam logic [FLD_W-1:0] FLD_ELSE = 3'd1;
    localparam logic [FLD_W-1:0] FLD_CAP  = 3'd2;
    localparam logic [FLD_W-1:0] FLD_CNT  = 3'd3;
    localparam logic [FLD_W-1:0] FLD_ACT  = 3'd4;

    typedef enum logic [2:0] {
        FN_AND   = 3'd0,
        FN_NAND  = 3'd1,
        FN_OR    = 3'd2,
        FN_NOR   = 3'd3,
        FN_XOR   = 3'd4,
        FN_XNOR  = 3'd5,
        FN_OFF6  = 3'd6,
        FN_NEVER = 3'd7
    } cond_fn_e;

    typedef struct packed {
        logic [TERMS-1:0] mask;
        cond_fn_e         fn;
    } cond_t;

    typedef struct packed {
        logic [ST_W-1:0]   else_tgt;
        logic              advance;
        logic [TIMERS-1:0] t_stop;
        logic [TIMERS-1:0] t_start;
        logic              set_run;
    } act_t;

    localparam cond_t COND_RST = '{mask: '0, fn: FN_NEVER};
endpackage

// File: rtl/tseq_cond_eval.sv
// Condition evaluator: applies one selectable logic function to the
// trigger terms picked by a mask. Purely combinational. Assumes the
// function codes of the package; unused codes give "never true".
module tseq_cond_eval
    import tseq_pkg::*;
(
    input  cond_t            cond_i,
    input  logic [TERMS-1:0] terms_i,
    output logic             match_o
);
    logic [TERMS-1:0] picked;
    logic             all_set, any_set, parity;

    // Reduce the masked terms three ways, then pick by function code.
    always_comb begin
        picked  = terms_i & cond_i.mask;
        all_set = &(terms_i | ~cond_i.mask);
        any_set = |picked;
        parity  = ^picked;
        unique case (cond_i.fn)
            FN_AND:  match_o = all_set;
            FN_NAND: match_o = ~all_set;
            FN_OR:   match_o = any_set;
            FN_NOR:  match_o = ~any_set;
            FN_XOR:  match_o = parity;
            FN_XNOR: match_o = ~parity;
            default: match_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tseq_timer.sv
// Interval timer: start clears and runs, stop halts and holds, stop wins
// a tie. Counts one per clock and saturates. Assumes start/stop are
// single-cycle requests from the sequencer.
module tseq_timer
    import tseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic [TIMER_W-1:0] limit_i,
    output logic               run_o,
    output logic               term_o
);
    logic [TIMER_W-1:0] cnt_q;
    logic               run_q;

    // Run flag and count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (stop_i) begin
            run_q <= 1'b0;
        end else if (start_i) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign run_o  = run_q;
    assign term_o = (cnt_q >= limit_i);

    // R10: a stop request leaves the timer halted.
    a_r10_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !run_q);
    // R10: a halted timer keeps its count unless restarted.
    a_r10_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tseq_cfg_store.sv
// Configuration store: address register with post-write increment,
// per-state condition/count/action records and timer limits. Serves the
// record of the current state. Assumes select and write never coincide
// (select wins if they do).
module tseq_cfg_store
    import tseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_i,
    input  logic               wr_i,
    input  logic [CFG_W-1:0]   data_i,
    input  logic [ST_W-1:0]    state_i,
    output cond_t              hit_o,
    output cond_t              else_o,
    output cond_t              cap_o,
    output logic [CNT_W-1:0]   need_o,
    output act_t               act_o,
    output logic [TIMER_W-1:0] limit_o [TIMERS]
);
    logic [ADDR_W-1:0]  addr_q;
    cond_t              hit_q  [STATES];
    cond_t              else_q [STATES];
    cond_t              cap_q  [STATES];
    logic [CNT_W-1:0]   need_q [STATES];
    act_t               act_q  [STATES];
    logic [TIMER_W-1:0] lim_q  [TIMERS];

    logic              timer_space;
    logic [ST_W-1:0]   w_state;
    logic [FLD_W-1:0]  w_field;
    cond_t             w_cond;
    act_t              w_act;

    // Split the address and shape the incoming word for each field type.
    always_comb begin
        timer_space = addr_q[ADDR_W-1];
        w_state     = addr_q[FLD_W +: ST_W];
        w_field     = addr_q[FLD_W-1:0];
        w_cond.mask = data_i[TERMS-1:0];
        w_cond.fn   = cond_fn_e'(data_i[14:12]);
        w_act.set_run  = data_i[0];
        w_act.t_start  = data_i[1 +: TIMERS];
        w_act.t_stop   = data_i[1 + TIMERS +: TIMERS];
        w_act.advance  = data_i[1 + 2*TIMERS];
        w_act.else_tgt = data_i[8 +: ST_W];
    end

    // Address register: loaded by select, stepped after each write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (sel_i)
            addr_q <= data_i[ADDR_W-1:0];
        else if (wr_i)
            addr_q <= addr_q + 1'b1;
    end

    // Per-state records: reset to "never", written one field at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STATES; s++) begin
                hit_q[s]  <= COND_RST;
                else_q[s] <= COND_RST;
                cap_q[s]  <= COND_RST;
                need_q[s] <= '0;
                act_q[s]  <= '0;
            end
        end else if (wr_i && !sel_i && !timer_space) begin
            case (w_field)
                FLD_HIT:  hit_q[w_state]  <= w_cond;
                FLD_ELSE: else_q[w_state] <= w_cond;
                FLD_CAP:  cap_q[w_state]  <= w_cond;
                FLD_CNT:  need_q[w_state] <= data_i[CNT_W-1:0];
                FLD_ACT:  act_q[w_state]  <= w_act;
                default:  ;
            endcase
        end
    end

    // Timer limits: reset to all ones so the terms start low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < TIMERS; t++)
                lim_q[t] <= '1;
        end else if (wr_i && !sel_i && timer_space) begin
            for (int t = 0; t < TIMERS; t++)
                if (int'(addr_q[FLD_W-1:0]) == t)
                    lim_q[t] <= data_i[TIMER_W-1:0];
        end
    end

    // Read port for the current state.
    always_comb begin
        hit_o  = hit_q[state_i];
        else_o = else_q[state_i];
        cap_o  = cap_q[state_i];
        need_o = need_q[state_i];
        act_o  = act_q[state_i];
        for (int t = 0; t < TIMERS; t++)
            limit_o[t] = lim_q[t];
    end

    // R2: a write without select steps the address by one.
    a_r2_addr_incr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !sel_i) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));
endmodule

// File: rtl/trig_sequencer.sv
// Trigger sequencer top: holds the state, the hit occurrence counter and
// the sticky run flag, evaluates the current state's three conditions
// and drives the timers. Assumes the terms are registered upstream and
// that arming happens after configuration.
module trig_sequencer
    import tseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arm_i,
    input  logic                 sample_valid_i,
    input  logic [EXT_TERMS-1:0] terms_i,
    input  logic                 cfg_sel_i,
    input  logic                 cfg_wr_i,
    input  logic [CFG_W-1:0]     cfg_data_i,
    output logic                 run_o,
    output logic                 capture_o,
    output logic [ST_W-1:0]      state_o,
    output logic [TIMERS-1:0]    timer_run_o
);
    cond_t              hit_c, else_c, cap_c;
    logic [CNT_W-1:0]   need;
    act_t               act;
    logic [TIMER_W-1:0] limit [TIMERS];

    logic [ST_W-1:0]    state_q, state_d;
    logic [CNT_W-1:0]   occ_q, occ_d;
    logic               armed_q, run_q, run_d;
    logic [TIMERS-1:0]  t_term, t_start, t_stop;
    logic [TERMS-1:0]   all_terms;
    logic [2:0]         cond_hit;
    logic               step, full_hit;
    logic [CNT_W:0]     need_eff;

    tseq_cfg_store u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (cfg_sel_i),
        .wr_i    (cfg_wr_i),
        .data_i  (cfg_data_i),
        .state_i (state_q),
        .hit_o   (hit_c),
        .else_o  (else_c),
        .cap_o   (cap_c),
        .need_o  (need),
        .act_o   (act),
        .limit_o (limit)
    );

    assign all_terms = {t_term, terms_i};

    // One evaluator per condition: 0 hit, 1 else, 2 capture.
    generate
        for (genvar c = 0; c < 3; c++) begin : g_cond
            cond_t sel_cond;
            assign sel_cond = (c == 0) ? hit_c : ((c == 1) ? else_c : cap_c);
            tseq_cond_eval u_eval (
                .cond_i  (sel_cond),
                .terms_i (all_terms),
                .match_o (cond_hit[c])
            );
        end
    endgenerate

    // One timer per feedback term.
    generate
        for (genvar t = 0; t < TIMERS; t++) begin : g_tmr
            tseq_timer u_tmr (
                .clk     (clk),
                .rst_n   (rst_n),
                .start_i (t_start[t]),
                .stop_i  (t_stop[t]),
                .limit_i (limit[t]),
                .run_o   (timer_run_o[t]),
                .term_o  (t_term[t])
            );
        end
    endgenerate

    // Step decision: count hits, fire actions, pick the next state.
    always_comb begin
        step     = armed_q && sample_valid_i;
        need_eff = (need == '0) ? (CNT_W+1)'(1) : {1'b0, need};
        full_hit = ({1'b0, occ_q} + 1'b1) >= need_eff;
        state_d  = state_q;
        occ_d    = occ_q;
        run_d    = run_q;
        t_start  = '0;
        t_stop   = '0;
        if (step) begin
            if (cond_hit[0]) begin
                if (full_hit) begin
                    occ_d   = '0;
                    run_d   = run_q | act.set_run;
                    t_start = act.t_start;
                    t_stop  = act.t_stop;
                    if (act.advance && (state_q != ST_W'(STATES-1)))
                        state_d = state_q + 1'b1;
                end else begin
                    occ_d = occ_q + 1'b1;
                end
            end else if (cond_hit[1]) begin
                state_d = act.else_tgt;
                occ_d   = '0;
            end
        end
    end

    // Sequencer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            state_q <= '0;
            occ_q   <= '0;
            run_q   <= 1'b0;
        end else begin
            armed_q <= armed_q | arm_i;
            state_q <= state_d;
            occ_q   <= occ_d;
            run_q   <= run_d;
        end
    end

    assign run_o     = run_q;
    assign state_o   = state_q;
    assign capture_o = step && (run_q || cond_hit[2]);

    // R6: run flag never drops once set.
    a_r6_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> run_q);
    // R4: without a valid armed sample the state holds.
    a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed_q && sample_valid_i) |=> $stable(state_q));
    // R9: capture is only requested for valid samples.
    a_r9_capture_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |-> sample_valid_i);
    // R5: entering a new state starts with a cleared occurrence count.
    a_r5_occ_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> (occ_q == '0));
    // R4: nothing happens before arming.
    a_r4_idle_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> (!capture_o && (state_q == '0)));
endmodule

// File: tb/trig_sequencer_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module trig_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_i = 1'b0;
    logic        sample_valid_i = 1'b0;
    logic [7:0]  terms_i = '0;
    logic        cfg_sel_i = 1'b0;
    logic        cfg_wr_i = 1'b0;
    logic [35:0] cfg_data_i = '0;
    logic        run_o, capture_o;
    logic [3:0]  state_o;
    logic [1:0]  timer_run_o;

    int n_chk = 0;
    int n_bad = 0;

    trig_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i),
        .sample_valid_i(sample_valid_i), .terms_i(terms_i),
        .cfg_sel_i(cfg_sel_i), .cfg_wr_i(cfg_wr_i), .cfg_data_i(cfg_data_i),
        .run_o(run_o), .capture_o(capture_o), .state_o(state_o),
        .timer_run_o(timer_run_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] cw(input int fn, input int mask);
        return 36'((fn << 12) | mask);
    endfunction

    function automatic logic [35:0] aw(input int setrun, input int tstart, input int tstop,
                                       input int adv, input int tgt);
        return 36'(setrun | (tstart << 1) | (tstop << 3) | (adv << 5) | (tgt << 8));
    endfunction

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; arm_i = 1'b0; sample_valid_i = 1'b0; terms_i = '0;
        cfg_sel_i = 1'b0; cfg_wr_i = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic cfg_sel(input int addr);
        cfg_sel_i = 1'b1; cfg_data_i = 36'(addr); tick(); cfg_sel_i = 1'b0;
    endtask

    task automatic cfg_wr(input logic [35:0] d);
        cfg_wr_i = 1'b1; cfg_data_i = d; tick(); cfg_wr_i = 1'b0;
    endtask

    // Burst-writes all five fields of one state (R2 auto-increment).
    task automatic cfg_state(input int s, input logic [35:0] h, input logic [35:0] e,
                             input logic [35:0] c, input int cnt, input logic [35:0] a);
        cfg_sel(s << 3);
        cfg_wr(h); cfg_wr(e); cfg_wr(c); cfg_wr(36'(cnt)); cfg_wr(a);
    endtask

    task automatic arm();
        arm_i = 1'b1; tick(); arm_i = 1'b0;
    endtask

    // Drives one cycle; returns capture_o as seen before the edge.
    task automatic step(input logic v, input logic [7:0] t, output logic cap);
        sample_valid_i = v; terms_i = t;
        #1 cap = capture_o;
        tick();
        sample_valid_i = 1'b0; terms_i = '0;
    endtask

    task automatic t_reset_state();
        logic cap;
        do_reset();
        chk("R1 state", state_o, 0);
        chk("R1 run", run_o, 0);
        chk("R1 timers", timer_run_o, 0);
        arm();
        step(1'b1, 8'hFF, cap);
        chk("R1 capture never", cap, 0);
        chk("R1 no move", state_o, 0);
        chk("R1 no run", run_o, 0);
    endtask

    task automatic t_functions();
        logic cap;
        for (int fn = 0; fn < 6; fn++) begin
            for (int p = 0; p < 4; p++) begin
                logic a, o, x, e;
                a = (p == 3); o = (p != 0); x = p[0] ^ p[1];
                e = (fn < 2) ? a : ((fn < 4) ? o : x);
                if (fn % 2 == 1) e = ~e;
                do_reset();
                cfg_state(0, cw(fn, 3), cw(7, 0), cw(7, 0), 1, aw(0, 0, 0, 1, 0));
                arm();
                step(1'b1, 8'(p), cap);
                chk($sformatf("R3 fn%0d pat%0d", fn, p), state_o, {3'b0, e});
            end
        end
    endtask

    task automatic t_arm_valid();
        logic cap;
        do_reset();
        cfg_state(0, cw(2, 1), cw(7, 0), cw(7, 0), 1, aw(0, 0, 0, 1, 0));
        step(1'b1, 8'h01, cap);
        chk("R4 unarmed", state_o, 0);
        arm();
        step(1'b0, 8'h01, cap);
        chk("R4 invalid sample", state_o, 0);
        step(1'b1, 8'h01, cap);
        chk("R4 valid sample", state_o, 1);
    endtask

    task automatic t_hit_count();
        logic cap;
        do_reset();
        cfg_state(0, cw(2, 1), cw(7, 0), cw(7, 0), 3, aw(0, 0, 0, 1, 0));
        cfg_state(1, cw(2, 1), cw(2, 2), cw(7, 0), 2, aw(0, 0, 0, 1, 1));
        cfg_state(2, cw(2, 1), cw(7, 0), cw(7, 0), 0, aw(0, 0, 0, 1, 0));
        arm();
        step(1'b1, 8'h01, cap);
        step(1'b0, 8'h01, cap);
        step(1'b1, 8'h01, cap);
        chk("R5 two of three", state_o, 0);
        step(1'b1, 8'h01, cap);
        chk("R5 third hit", state_o, 1);
        step(1'b1, 8'h01, cap);
        step(1'b1, 8'h02, cap);
        step(1'b1, 8'h01, cap);
        chk("R5 cleared by re-entry", state_o, 1);
        step(1'b1, 8'h01, cap);
        chk("R5 second after clear", state_o, 2);
        step(1'b1, 8'h01, cap);
        chk("R5 zero count as one", state_o, 3);
    endtask

    task automatic t_flow();
        logic cap;
        do_reset();
        cfg_state(0, cw(2, 1), cw(2, 2), cw(7, 0), 1, aw(1, 0, 0, 0, 5));
        cfg_state(5, cw(7, 0), cw(2, 2), cw(7, 0), 1, aw(0, 0, 0, 0, 15));
        cfg_state(15, cw(2, 1), cw(7, 0), cw(7, 0), 1, aw(0, 0, 0, 1, 0));
        arm();
        step(1'b1, 8'h00, cap);
        chk("R8 stay state", state_o, 0);
        chk("R8 no run", run_o, 0);
        step(1'b1, 8'h03, cap);
        chk("R7 hit over else", state_o, 0);
        chk("R6 run set", run_o, 1);
        step(1'b1, 8'h02, cap);
        chk("R7 else jump", state_o, 5);
        chk("R6 run sticky", run_o, 1);
        step(1'b1, 8'h02, cap);
        chk("R7 jump to last", state_o, 15);
        step(1'b1, 8'h01, cap);
        chk("R6 last state holds", state_o, 15);
    endtask

    task automatic t_capture();
        logic cap;
        do_reset();
        cfg_state(0, cw(2, 1), cw(7, 0), cw(2, 4), 1, aw(1, 0, 0, 0, 0));
        step(1'b1, 8'h04, cap);
        chk("R9 unarmed", cap, 0);
        arm();
        step(1'b1, 8'h00, cap);
        chk("R9 cond false", cap, 0);
        step(1'b1, 8'h04, cap);
        chk("R9 cond true", cap, 1);
        step(1'b0, 8'h04, cap);
        chk("R9 no valid", cap, 0);
        step(1'b1, 8'h01, cap);
        chk("R9 before run", cap, 0);
        step(1'b1, 8'h00, cap);
        chk("R9 after run", cap, 1);
    endtask

    task automatic t_timers();
        logic cap;
        do_reset();
        cfg_sel(8'h80);
        cfg_wr(36'd5); cfg_wr(36'd3);
        cfg_state(0, cw(2, 1), cw(7, 0), cw(7, 0), 1, aw(0, 1, 0, 1, 0));
        cfg_state(1, cw(2, 12'h100), cw(7, 0), cw(7, 0), 1, aw(0, 0, 0, 1, 0));
        cfg_state(2, cw(2, 1), cw(7, 0), cw(7, 0), 1, aw(0, 0, 1, 1, 0));
        cfg_state(3, cw(2, 1), cw(7, 0), cw(7, 0), 1, aw(0, 2, 2, 1, 0));
        arm();
        chk("R10 idle before start", timer_run_o, 0);
        step(1'b1, 8'h01, cap);
        chk("R10 timer0 running", timer_run_o, 1);
        for (int i = 0; i < 5; i++) step(1'b1, 8'h00, cap);
        chk("R10 before limit", state_o, 1);
        step(1'b1, 8'h00, cap);
        chk("R10 term at limit", state_o, 2);
        step(1'b1, 8'h01, cap);
        chk("R10 stopped", timer_run_o, 0);
        step(1'b1, 8'h01, cap);
        chk("R10 stop wins", timer_run_o, 0);
        chk("R2 burst reached state 3", state_o, 4);
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_functions();
        t_arm_valid();
        t_hit_count();
        t_flow();
        t_capture();
        t_timers();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule